// File: doc/BRIEF.md
# Banked Memory Access Timing Controller

This block is the data-memory front end shared by a processor port and a DMA port. Every request address is decoded into a register region, a static RAM region or a byte-wide persistent-storage region. Each region and operation has its own fixed latency before the response appears. The storage behind the front end is held in internal arrays. Each port uses a valid/ready request handshake and has one transaction in flight at a time.

The address space is split into four independent sections. Both ports may be accepted in the same cycle when they target different sections. When they target the same free section, the processor port wins and the DMA port waits with ready low until the section is released. The DMA port can also run burst reads. A burst from static RAM streams one byte per cycle, and a burst from persistent storage streams one byte every second cycle. A burst keeps its section until its final beat. The lowest sixteen register addresses also accept single-bit set, clear and test operations.

Top module: `bank_mem_timer`

## Requirements
- R1: Op code 0 is read and op code 1 is write. A read or write to the register region (0x000-0x03F) gives its response in the cycle after acceptance, and a read returns the stored byte.
- R2: A write to static RAM (0x100-0x1FF) is acknowledged in the cycle after acceptance. A single read from static RAM responds two cycles after acceptance, with nothing shown in the cycle between.
- R3: A write to persistent storage (0x400-0x43F) is acknowledged in the cycle after acceptance. A single read from it responds three cycles after acceptance.
- R4: A DMA read from static RAM with burst field N returns N+1 bytes. The first byte appears at the single-read latency and each later byte follows in the next cycle. Addresses increment and wrap inside the 128-byte half they started in, and the last flag is set only on the final byte.
- R5: A DMA burst read from persistent storage returns N+1 bytes, one every second cycle after the first. Addresses wrap inside the 64-byte region.
- R6: There are four sections: 0 is the register region, 1 is 0x100-0x17F, 2 is 0x180-0x1FF and 3 is persistent storage. Requests to different sections are accepted in the same cycle and proceed independently.
- R7: When both ports present requests to the same free section in the same cycle, the processor port is accepted. The DMA port sees ready low until the cycle after the processor's response.
- R8: A running burst holds its section up to and including its final beat. During that time, requests to other sections are accepted.
- R9: At register addresses 0x000-0x00F, op 2 sets, op 3 clears and op 4 tests the bit selected by write data bits [2:0]. Each takes one cycle. A test returns the bit in data bit 0 with all other bits zero.
- R10: An undecoded address, an op code above 4, or a bit operation outside 0x000-0x00F responds in the next cycle with the error flag set and zero data. Such a request changes no stored byte.
- R11: After reset, every stored byte is zero, no response is shown and an idle port is ready.
- R12: A port accepts a new request only from the cycle after its previous final response. A DMA write ignores the burst field and gives exactly one response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_ready | output | 1 | Processor request accepted this cycle |
| cpu_addr | input | 12 | Processor byte address |
| cpu_op | input | 3 | Processor operation code |
| cpu_wdata | input | 8 | Processor write data or bit index |
| cpu_rsp_valid | output | 1 | Processor response strobe |
| cpu_rsp_data | output | 8 | Processor read data |
| cpu_rsp_err | output | 1 | Processor error flag |
| cpu_rsp_last | output | 1 | Processor final-response flag |
| dma_valid | input | 1 | DMA request present |
| dma_ready | output | 1 | DMA request accepted this cycle |
| dma_addr | input | 12 | DMA byte address |
| dma_op | input | 3 | DMA operation code |
| dma_wdata | input | 8 | DMA write data or bit index |
| dma_blen | input | 4 | DMA burst field, beats minus one |
| dma_rsp_valid | output | 1 | DMA response strobe |
| dma_rsp_data | output | 8 | DMA read data |
| dma_rsp_err | output | 1 | DMA error flag |
| dma_rsp_last | output | 1 | DMA final-beat flag |

## Verification
Two things can fall in the same cycle: a processor access and a DMA access or burst beat. They may target different sections, which must overlap, or the same section, which must be serialised. The bench raises both valids on the same clock edge, first with disjoint sections and then with a shared one. It also issues processor requests while a DMA burst is streaming. It judges each case by the ready levels seen before the edge and by the exact cycle in which each port's response strobe, data and last flag appear.

// File: rtl/bmt_pkg.sv
package bmt_pkg;
    localparam int AW        = 12;
    localparam int DW        = 8;
    localparam int IDX_W     = 8;
    localparam int NSEC      = 4;
    localparam int IO_N      = 64;
    localparam int SR_N      = 256;
    localparam int EE_N      = 64;
    localparam int SR_BANK_W = $clog2(SR_N) - 1;
    localparam int IO_IW     = $clog2(IO_N);
    localparam int SR_IW     = $clog2(SR_N);
    localparam int EE_IW     = $clog2(EE_N);

    localparam logic [AW-1:0] IO_LO   = 12'h000;
    localparam logic [AW-1:0] SR_LO   = 12'h100;
    localparam logic [AW-1:0] EE_LO   = 12'h400;
    localparam logic [AW-1:0] IO_HI   = IO_LO + AW'(IO_N);
    localparam logic [AW-1:0] SR_HI   = SR_LO + AW'(SR_N);
    localparam logic [AW-1:0] EE_HI   = EE_LO + AW'(EE_N);
    localparam logic [AW-1:0] BIT_TOP = 12'h010;

    localparam logic [2:0] OP_READ  = 3'd0;
    localparam logic [2:0] OP_WRITE = 3'd1;
    localparam logic [2:0] OP_BSET  = 3'd2;
    localparam logic [2:0] OP_BCLR  = 3'd3;
    localparam logic [2:0] OP_BTEST = 3'd4;

    typedef enum logic [1:0] {REG_IO, REG_SRAM, REG_EE, REG_NONE} region_e;

    typedef struct packed {
        region_e          region;
        logic [1:0]       sec;
        logic [IDX_W-1:0] idx;
        logic             err;
    } dec_t;

    function automatic dec_t decode(input logic [AW-1:0] a, input logic [2:0] op);
        dec_t          d;
        logic [AW-1:0] off;
        logic          bitop;
        bitop    = (op == OP_BSET) || (op == OP_BCLR) || (op == OP_BTEST);
        off      = '0;
        d.region = REG_NONE;
        d.sec    = 2'd0;
        d.idx    = '0;
        d.err    = 1'b1;
        if (a >= IO_LO && a < IO_HI) begin
            off      = a - IO_LO;
            d.region = REG_IO;
            d.sec    = 2'd0;
            d.idx    = off[IDX_W-1:0];
            d.err    = bitop && (off >= BIT_TOP);
        end else if (a >= SR_LO && a < SR_HI) begin
            off      = a - SR_LO;
            d.region = REG_SRAM;
            d.sec    = off[SR_BANK_W] ? 2'd2 : 2'd1;
            d.idx    = off[IDX_W-1:0];
            d.err    = bitop;
        end else if (a >= EE_LO && a < EE_HI) begin
            off      = a - EE_LO;
            d.region = REG_EE;
            d.sec    = 2'd3;
            d.idx    = off[IDX_W-1:0];
            d.err    = bitop;
        end
        if (op > OP_BTEST) d.err = 1'b1;
        return d;
    endfunction
endpackage

// File: rtl/bmt_store.sv
module bmt_store
    import bmt_pkg::*;
#(
    parameter int NPORT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we    [NPORT],
    input  region_e          wreg  [NPORT],
    input  logic [IDX_W-1:0] widx  [NPORT],
    input  logic [2:0]       wop   [NPORT],
    input  logic [DW-1:0]    wdata [NPORT],
    input  region_e          rreg  [NPORT],
    input  logic [IDX_W-1:0] ridx  [NPORT],
    input  logic [2:0]       rop   [NPORT],
    input  logic [2:0]       rbit  [NPORT],
    output logic [DW-1:0]    rdata [NPORT]
);
    logic [DW-1:0] io_q [IO_N];
    logic [DW-1:0] sr_q [SR_N];
    logic [DW-1:0] ee_q [EE_N];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < IO_N; i++) io_q[i] <= '0;
            for (int i = 0; i < SR_N; i++) sr_q[i] <= '0;
            for (int i = 0; i < EE_N; i++) ee_q[i] <= '0;
        end else begin
            for (int p = 0; p < NPORT; p++) begin
                if (we[p]) begin
                    case (wreg[p])
                        REG_IO: begin
                            if (wop[p] == OP_BSET)
                                io_q[widx[p][IO_IW-1:0]] <= io_q[widx[p][IO_IW-1:0]] | (DW'(1) << wdata[p][2:0]);
                            else if (wop[p] == OP_BCLR)
                                io_q[widx[p][IO_IW-1:0]] <= io_q[widx[p][IO_IW-1:0]] & ~(DW'(1) << wdata[p][2:0]);
                            else
                                io_q[widx[p][IO_IW-1:0]] <= wdata[p];
                        end
                        REG_SRAM: sr_q[widx[p][SR_IW-1:0]] <= wdata[p];
                        REG_EE:   ee_q[widx[p][EE_IW-1:0]] <= wdata[p];
                        default: ;
                    endcase
                end
            end
        end
    end

    always_comb begin
        for (int p = 0; p < NPORT; p++) begin
            case (rreg[p])
                REG_IO: begin
                    rdata[p] = io_q[ridx[p][IO_IW-1:0]];
                    if (rop[p] == OP_BTEST) rdata[p] = {{(DW-1){1'b0}}, rdata[p][rbit[p]]};
                end
                REG_SRAM: rdata[p] = sr_q[ridx[p][SR_IW-1:0]];
                REG_EE:   rdata[p] = ee_q[ridx[p][EE_IW-1:0]];
                default:  rdata[p] = '0;
            endcase
        end
    end
endmodule

// File: rtl/bmt_port.sv
module bmt_port
    import bmt_pkg::*;
#(
    parameter int LAT_IO    = 1,
    parameter int LAT_SR_RD = 2,
    parameter int LAT_SR_WR = 1,
    parameter int LAT_EE_RD = 3,
    parameter int LAT_EE_WR = 1,
    parameter int GAP_SR    = 1,
    parameter int GAP_EE    = 2,
    parameter int BURST_EN  = 1,
    parameter int BLEN_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  dec_t              dec,
    input  logic [2:0]        op,
    input  logic [2:0]        bsel,
    input  logic [BLEN_W-1:0] blen,
    output logic              act,
    output logic [1:0]        sec,
    output logic              err,
    output region_e           region,
    output logic [IDX_W-1:0]  idx,
    output logic [2:0]        op_q,
    output logic [2:0]        bsel_q,
    output logic              rsp_valid,
    output logic              rsp_last
);
    localparam int LMAX = (LAT_EE_RD > GAP_EE) ? LAT_EE_RD : GAP_EE;
    localparam int CW   = $clog2(LMAX + 1);

    typedef struct packed {
        logic              act;
        region_e           region;
        logic [1:0]        sec;
        logic [IDX_W-1:0]  idx;
        logic              err;
        logic [2:0]        op;
        logic [2:0]        bsel;
        logic [CW-1:0]     cnt;
        logic [BLEN_W-1:0] beats;
    } st_t;

    st_t s_d, s_q;

    function automatic logic [IDX_W-1:0] bump(input region_e r, input logic [IDX_W-1:0] i);
        logic [IDX_W-1:0] m;
        m = (r == REG_EE) ? IDX_W'((1 << EE_IW) - 1) : IDX_W'((1 << SR_BANK_W) - 1);
        return (i & ~m) | ((i + 1'b1) & m);
    endfunction

    always_comb begin
        int lat;
        s_d = s_q;
        lat = 1;
        if (accept) begin
            if (!dec.err) begin
                case (dec.region)
                    REG_IO:   lat = LAT_IO;
                    REG_SRAM: lat = (op == OP_READ) ? LAT_SR_RD : LAT_SR_WR;
                    REG_EE:   lat = (op == OP_READ) ? LAT_EE_RD : LAT_EE_WR;
                    default:  lat = 1;
                endcase
            end
            s_d.act    = 1'b1;
            s_d.region = dec.region;
            s_d.sec    = dec.sec;
            s_d.idx    = dec.idx;
            s_d.err    = dec.err;
            s_d.op     = op;
            s_d.bsel   = bsel;
            s_d.cnt    = CW'(lat - 1);
            s_d.beats  = (BURST_EN != 0 && op == OP_READ && !dec.err &&
                          (dec.region == REG_SRAM || dec.region == REG_EE)) ? blen : '0;
        end else if (s_q.act) begin
            if (s_q.cnt != '0) begin
                s_d.cnt = s_q.cnt - 1'b1;
            end else if (s_q.beats == '0) begin
                s_d.act = 1'b0;
            end else begin
                s_d.beats = s_q.beats - 1'b1;
                s_d.idx   = bump(s_q.region, s_q.idx);
                s_d.cnt   = CW'(((s_q.region == REG_EE) ? GAP_EE : GAP_SR) - 1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign act       = s_q.act;
    assign sec       = s_q.sec;
    assign err       = s_q.err;
    assign region    = s_q.region;
    assign idx       = s_q.idx;
    assign op_q      = s_q.op;
    assign bsel_q    = s_q.bsel;
    assign rsp_valid = s_q.act && (s_q.cnt == '0);
    assign rsp_last  = s_q.beats == '0;

    p_io_lat_r1: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !dec.err && dec.region == REG_IO |=> rsp_valid);
    p_write_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !dec.err && op == OP_WRITE |=> rsp_valid && rsp_last);
    p_sram_rd_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !dec.err && dec.region == REG_SRAM && op == OP_READ |=> !rsp_valid ##1 rsp_valid);
    p_ee_rd_lat_r3: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !dec.err && dec.region == REG_EE && op == OP_READ |=> !rsp_valid ##1 !rsp_valid ##1 rsp_valid);
    p_sram_stream_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_last && region == REG_SRAM |=> rsp_valid);
    p_ee_stream_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_last && region == REG_EE |=> !rsp_valid ##1 rsp_valid);
    p_err_fast_r10: assert property (@(posedge clk) disable iff (!rst_n)
        accept && dec.err |=> rsp_valid && rsp_last && err);
endmodule

// File: rtl/bank_mem_timer.sv
module bank_mem_timer
    import bmt_pkg::*;
#(
    parameter int BLEN_W    = 4,
    parameter int LAT_IO    = 1,
    parameter int LAT_SR_RD = 2,
    parameter int LAT_SR_WR = 1,
    parameter int LAT_EE_RD = 3,
    parameter int LAT_EE_WR = 1,
    parameter int GAP_SR    = 1,
    parameter int GAP_EE    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_valid,
    output logic              cpu_ready,
    input  logic [11:0]       cpu_addr,
    input  logic [2:0]        cpu_op,
    input  logic [7:0]        cpu_wdata,
    output logic              cpu_rsp_valid,
    output logic [7:0]        cpu_rsp_data,
    output logic              cpu_rsp_err,
    output logic              cpu_rsp_last,
    input  logic              dma_valid,
    output logic              dma_ready,
    input  logic [11:0]       dma_addr,
    input  logic [2:0]        dma_op,
    input  logic [7:0]        dma_wdata,
    input  logic [BLEN_W-1:0] dma_blen,
    output logic              dma_rsp_valid,
    output logic [7:0]        dma_rsp_data,
    output logic              dma_rsp_err,
    output logic              dma_rsp_last
);
    dec_t             c_dec, d_dec;
    logic             c_act, d_act, c_err, d_err, c_acc, d_acc;
    logic [1:0]       c_sec, d_sec;
    region_e          c_reg, d_reg;
    logic [IDX_W-1:0] c_idx, d_idx;
    logic [2:0]       c_opq, d_opq, c_bit, d_bit;
    logic [NSEC-1:0]  busy;
    logic             cpu_claims;

    logic             st_we    [2];
    region_e          st_wreg  [2];
    logic [IDX_W-1:0] st_widx  [2];
    logic [2:0]       st_wop   [2];
    logic [DW-1:0]    st_wdata [2];
    region_e          st_rreg  [2];
    logic [IDX_W-1:0] st_ridx  [2];
    logic [2:0]       st_rop   [2];
    logic [2:0]       st_rbit  [2];
    logic [DW-1:0]    st_rdata [2];

    assign c_dec = decode(cpu_addr, cpu_op);
    assign d_dec = decode(dma_addr, dma_op);

    for (genvar s = 0; s < NSEC; s++) begin : g_busy
        assign busy[s] = (c_act && !c_err && c_sec == 2'(s)) ||
                         (d_act && !d_err && d_sec == 2'(s));
    end

    assign cpu_claims = cpu_valid && !c_act && !c_dec.err && !busy[c_dec.sec];
    assign cpu_ready  = !c_act && (c_dec.err || !busy[c_dec.sec]);
    assign dma_ready  = !d_act && (d_dec.err ||
                        (!busy[d_dec.sec] && !(cpu_claims && c_dec.sec == d_dec.sec)));
    assign c_acc = cpu_valid && cpu_ready;
    assign d_acc = dma_valid && dma_ready;

    bmt_port #(
        .LAT_IO(LAT_IO), .LAT_SR_RD(LAT_SR_RD), .LAT_SR_WR(LAT_SR_WR),
        .LAT_EE_RD(LAT_EE_RD), .LAT_EE_WR(LAT_EE_WR),
        .GAP_SR(GAP_SR), .GAP_EE(GAP_EE), .BURST_EN(0), .BLEN_W(BLEN_W)
    ) u_cpu_port (
        .clk(clk), .rst_n(rst_n), .accept(c_acc), .dec(c_dec), .op(cpu_op),
        .bsel(cpu_wdata[2:0]), .blen('0), .act(c_act), .sec(c_sec), .err(c_err),
        .region(c_reg), .idx(c_idx), .op_q(c_opq), .bsel_q(c_bit),
        .rsp_valid(cpu_rsp_valid), .rsp_last(cpu_rsp_last)
    );

    bmt_port #(
        .LAT_IO(LAT_IO), .LAT_SR_RD(LAT_SR_RD), .LAT_SR_WR(LAT_SR_WR),
        .LAT_EE_RD(LAT_EE_RD), .LAT_EE_WR(LAT_EE_WR),
        .GAP_SR(GAP_SR), .GAP_EE(GAP_EE), .BURST_EN(1), .BLEN_W(BLEN_W)
    ) u_dma_port (
        .clk(clk), .rst_n(rst_n), .accept(d_acc), .dec(d_dec), .op(dma_op),
        .bsel(dma_wdata[2:0]), .blen(dma_blen), .act(d_act), .sec(d_sec), .err(d_err),
        .region(d_reg), .idx(d_idx), .op_q(d_opq), .bsel_q(d_bit),
        .rsp_valid(dma_rsp_valid), .rsp_last(dma_rsp_last)
    );

    always_comb begin
        st_we[0]    = c_acc && !c_dec.err && (cpu_op == OP_WRITE || cpu_op == OP_BSET || cpu_op == OP_BCLR);
        st_we[1]    = d_acc && !d_dec.err && (dma_op == OP_WRITE || dma_op == OP_BSET || dma_op == OP_BCLR);
        st_wreg[0]  = c_dec.region;
        st_wreg[1]  = d_dec.region;
        st_widx[0]  = c_dec.idx;
        st_widx[1]  = d_dec.idx;
        st_wop[0]   = cpu_op;
        st_wop[1]   = dma_op;
        st_wdata[0] = cpu_wdata;
        st_wdata[1] = dma_wdata;
        st_rreg[0]  = c_reg;
        st_rreg[1]  = d_reg;
        st_ridx[0]  = c_idx;
        st_ridx[1]  = d_idx;
        st_rop[0]   = c_opq;
        st_rop[1]   = d_opq;
        st_rbit[0]  = c_bit;
        st_rbit[1]  = d_bit;
    end

    bmt_store #(.NPORT(2)) u_store (
        .clk(clk), .rst_n(rst_n), .we(st_we), .wreg(st_wreg), .widx(st_widx),
        .wop(st_wop), .wdata(st_wdata), .rreg(st_rreg), .ridx(st_ridx),
        .rop(st_rop), .rbit(st_rbit), .rdata(st_rdata)
    );

    assign cpu_rsp_err  = cpu_rsp_valid && c_err;
    assign dma_rsp_err  = dma_rsp_valid && d_err;
    assign cpu_rsp_data = (cpu_rsp_valid && !c_err) ? st_rdata[0] : '0;
    assign dma_rsp_data = (dma_rsp_valid && !d_err) ? st_rdata[1] : '0;

    p_section_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(c_act && d_act && !c_err && !d_err && c_sec == d_sec));
    p_cpu_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rsp_valid |-> cpu_rsp_last);
    p_err_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dma_rsp_err |-> dma_rsp_data == '0);
endmodule

// File: tb/bank_mem_timer_tb.sv
module bank_mem_timer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_valid = 1'b0, dma_valid = 1'b0;
    logic [11:0] cpu_addr = '0, dma_addr = '0;
    logic [2:0] cpu_op = '0, dma_op = '0;
    logic [7:0] cpu_wdata = '0, dma_wdata = '0;
    logic [3:0] dma_blen = '0;
    logic       cpu_ready, dma_ready;
    logic       cpu_rsp_valid, cpu_rsp_err, cpu_rsp_last;
    logic       dma_rsp_valid, dma_rsp_err, dma_rsp_last;
    logic [7:0] cpu_rsp_data, dma_rsp_data;
    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    bank_mem_timer u_dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_addr(cpu_addr),
        .cpu_op(cpu_op), .cpu_wdata(cpu_wdata), .cpu_rsp_valid(cpu_rsp_valid),
        .cpu_rsp_data(cpu_rsp_data), .cpu_rsp_err(cpu_rsp_err), .cpu_rsp_last(cpu_rsp_last),
        .dma_valid(dma_valid), .dma_ready(dma_ready), .dma_addr(dma_addr),
        .dma_op(dma_op), .dma_wdata(dma_wdata), .dma_blen(dma_blen),
        .dma_rsp_valid(dma_rsp_valid), .dma_rsp_data(dma_rsp_data),
        .dma_rsp_err(dma_rsp_err), .dma_rsp_last(dma_rsp_last)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic cpu_acc(input logic [11:0] a, input logic [2:0] op, input logic [7:0] wd);
        @(negedge clk);
        cpu_valid = 1'b1; cpu_addr = a; cpu_op = op; cpu_wdata = wd;
        #1;
        while (!cpu_ready) step();
        @(posedge clk);
        #1 cpu_valid = 1'b0;
    endtask

    task automatic dma_acc(input logic [11:0] a, input logic [2:0] op, input logic [7:0] wd,
                           input logic [3:0] bl);
        @(negedge clk);
        dma_valid = 1'b1; dma_addr = a; dma_op = op; dma_wdata = wd; dma_blen = bl;
        #1;
        while (!dma_ready) step();
        @(posedge clk);
        #1 dma_valid = 1'b0;
    endtask

    // exp_data < 0 skips the data comparison
    task automatic cpu_do(input logic [11:0] a, input logic [2:0] op, input logic [7:0] wd,
                          input int lat, input string req, input int exp_data, input int exp_err);
        cpu_acc(a, op, wd);
        for (int k = 1; k < lat; k++) begin
            step();
            chk(req, cpu_rsp_valid, 0);
        end
        step();
        chk(req, cpu_rsp_valid, 1);
        chk(req, cpu_rsp_err, exp_err);
        if (exp_data >= 0) chk(req, cpu_rsp_data, exp_data);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) step();
        chk("R11 rsp idle cpu", cpu_rsp_valid, 0);
        chk("R11 rsp idle dma", dma_rsp_valid, 0);
        rst_n = 1'b1;
        step();
        chk("R11 cpu ready", cpu_ready, 1);
        chk("R11 dma ready", dma_ready, 1);
        cpu_do(12'h007, 3'd0, 8'h00, 1, "R11 zero storage io", 0, 0);
        cpu_do(12'h1F0, 3'd0, 8'h00, 2, "R11 zero storage sram", 0, 0);
    endtask

    task automatic t_io();
        cpu_do(12'h005, 3'd1, 8'hA5, 1, "R1 io write", -1, 0);
        cpu_do(12'h005, 3'd0, 8'h00, 1, "R1 io read", 8'hA5, 0);
    endtask

    task automatic t_sram();
        cpu_do(12'h123, 3'd1, 8'h3C, 1, "R2 sram write", -1, 0);
        cpu_do(12'h123, 3'd0, 8'h00, 2, "R2 sram read", 8'h3C, 0);
    endtask

    task automatic t_ee();
        cpu_do(12'h410, 3'd1, 8'h77, 1, "R3 ee write", -1, 0);
        cpu_do(12'h410, 3'd0, 8'h00, 3, "R3 ee read", 8'h77, 0);
    endtask

    task automatic t_bits();
        cpu_do(12'h002, 3'd2, 8'h03, 1, "R9 bset", -1, 0);
        cpu_do(12'h002, 3'd2, 8'h00, 1, "R9 bset0", -1, 0);
        cpu_do(12'h002, 3'd3, 8'h03, 1, "R9 bclr", -1, 0);
        cpu_do(12'h002, 3'd4, 8'h00, 1, "R9 btest set bit", 1, 0);
        cpu_do(12'h002, 3'd4, 8'h03, 1, "R9 btest clear bit", 0, 0);
        cpu_do(12'h002, 3'd0, 8'h00, 1, "R9 byte after bit ops", 8'h01, 0);
    endtask

    task automatic t_err();
        cpu_do(12'h300, 3'd0, 8'h00, 1, "R10 undecoded", 0, 1);
        cpu_do(12'h020, 3'd1, 8'h55, 1, "R10 setup write", -1, 0);
        cpu_do(12'h020, 3'd2, 8'h01, 1, "R10 bit op above 0x00F", 0, 1);
        cpu_do(12'h020, 3'd0, 8'h00, 1, "R10 no change", 8'h55, 0);
        cpu_do(12'h005, 3'd6, 8'h00, 1, "R10 bad op", 0, 1);
    endtask

    task automatic t_burst_sram();
        cpu_do(12'h17E, 3'd1, 8'h01, 1, "R4 preload", -1, 0);
        cpu_do(12'h17F, 3'd1, 8'h02, 1, "R4 preload", -1, 0);
        cpu_do(12'h100, 3'd1, 8'h03, 1, "R4 preload", -1, 0);
        dma_acc(12'h17E, 3'd0, 8'h00, 4'd2);
        step(); chk("R4 gap before first", dma_rsp_valid, 0);
        step(); chk("R4 beat0 valid", dma_rsp_valid, 1); chk("R4 beat0 data", dma_rsp_data, 1);
                chk("R4 beat0 last", dma_rsp_last, 0);
        step(); chk("R4 beat1 valid", dma_rsp_valid, 1); chk("R4 beat1 data", dma_rsp_data, 2);
        step(); chk("R4 beat2 wrap data", dma_rsp_data, 3); chk("R4 beat2 last", dma_rsp_last, 1);
        step(); chk("R4 burst done", dma_rsp_valid, 0);
    endtask

    task automatic t_burst_ee();
        cpu_do(12'h43F, 3'd1, 8'h09, 1, "R5 preload", -1, 0);
        cpu_do(12'h400, 3'd1, 8'h08, 1, "R5 preload", -1, 0);
        dma_acc(12'h43F, 3'd0, 8'h00, 4'd1);
        step(); chk("R5 wait1", dma_rsp_valid, 0);
        step(); chk("R5 wait2", dma_rsp_valid, 0);
        step(); chk("R5 beat0", dma_rsp_valid, 1); chk("R5 beat0 data", dma_rsp_data, 9);
        step(); chk("R5 spacing", dma_rsp_valid, 0);
        step(); chk("R5 beat1", dma_rsp_valid, 1); chk("R5 beat1 wrap data", dma_rsp_data, 8);
                chk("R5 beat1 last", dma_rsp_last, 1);
        step(); chk("R5 done", dma_rsp_valid, 0);
    endtask

    task automatic t_parallel();
        @(negedge clk);
        cpu_valid = 1'b1; cpu_addr = 12'h006; cpu_op = 3'd1; cpu_wdata = 8'h11;
        dma_valid = 1'b1; dma_addr = 12'h123; dma_op = 3'd0; dma_blen = 4'd0;
        #1;
        chk("R6 cpu ready", cpu_ready, 1);
        chk("R6 dma ready same cycle", dma_ready, 1);
        @(posedge clk);
        #1 begin cpu_valid = 1'b0; dma_valid = 1'b0; end
        step(); chk("R6 cpu ack", cpu_rsp_valid, 1); chk("R6 dma pending", dma_rsp_valid, 0);
        step(); chk("R6 dma rsp", dma_rsp_valid, 1); chk("R6 dma data", dma_rsp_data, 8'h3C);
    endtask

    task automatic t_conflict();
        @(negedge clk);
        cpu_valid = 1'b1; cpu_addr = 12'h123; cpu_op = 3'd0;
        dma_valid = 1'b1; dma_addr = 12'h124; dma_op = 3'd0; dma_blen = 4'd0;
        #1;
        chk("R7 cpu wins", cpu_ready, 1);
        chk("R7 dma waits", dma_ready, 0);
        @(posedge clk);
        #1 cpu_valid = 1'b0;
        step(); chk("R7 dma still waits c1", dma_ready, 0);
        step(); chk("R7 cpu rsp", cpu_rsp_valid, 1); chk("R7 cpu data", cpu_rsp_data, 8'h3C);
                chk("R7 dma waits c2", dma_ready, 0);
        step(); chk("R7 dma released", dma_ready, 1);
        @(posedge clk);
        #1 dma_valid = 1'b0;
        step(); chk("R7 dma latency", dma_rsp_valid, 0);
        step(); chk("R7 dma rsp", dma_rsp_valid, 1); chk("R7 dma data", dma_rsp_data, 0);
    endtask

    task automatic t_hold();
        dma_acc(12'h100, 3'd0, 8'h00, 4'd3);
        @(negedge clk);
        cpu_valid = 1'b1; cpu_addr = 12'h410; cpu_op = 3'd0;
        #1 chk("R8 other section accepted", cpu_ready, 1);
        @(posedge clk);
        #1 cpu_valid = 1'b0;
        step(); chk("R8 beat0", dma_rsp_valid, 1);
        step(); chk("R8 beat1", dma_rsp_valid, 1);
        step(); chk("R8 cpu ee rsp", cpu_rsp_valid, 1); chk("R8 cpu ee data", cpu_rsp_data, 8'h77);
                chk("R8 beat2 overlaps", dma_rsp_valid, 1);
        @(negedge clk);
        cpu_valid = 1'b1; cpu_addr = 12'h150; cpu_op = 3'd0;
        #1 chk("R8 held at last beat", cpu_ready, 0);
        chk("R8 last beat flag", dma_rsp_last, 1);
        step(); chk("R8 released", cpu_ready, 1);
        @(posedge clk);
        #1 cpu_valid = 1'b0;
        repeat (2) step();
    endtask

    task automatic t_dma_wr();
        dma_acc(12'h1A0, 3'd1, 8'h42, 4'd5);
        @(negedge clk);
        dma_valid = 1'b1; dma_addr = 12'h1A0; dma_op = 3'd0; dma_blen = 4'd0;
        #1;
        chk("R12 write single rsp", dma_rsp_valid, 1);
        chk("R12 write last", dma_rsp_last, 1);
        chk("R12 busy in rsp cycle", dma_ready, 0);
        step();
        chk("R12 no extra beat", dma_rsp_valid, 0);
        chk("R12 ready after rsp", dma_ready, 1);
        @(posedge clk);
        #1 dma_valid = 1'b0;
        step();
        step(); chk("R12 readback", dma_rsp_data, 8'h42);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        t_reset();
        t_io();
        t_sram();
        t_ee();
        t_bits();
        t_err();
        t_burst_sram();
        t_burst_ee();
        t_parallel();
        t_conflict();
        t_hold();
        t_dma_wr();
        repeat (3) step();
        finish_run();
    end
endmodule